// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block is the general-purpose register storage of a small RISC-style processor core. It holds a parameterised set of registers (32 by 32 bits by default) and offers two combinational read ports and two write ports. The write ports are independent and commit on the same clock edge. A swap instruction can therefore exchange two registers in one cycle by writing each source value into the other destination.

Each write port has its own address, data and enable. Data from a port reaches only the register that port's address selects. When both enabled ports name the same register, the primary port wins and the secondary data is dropped. In that cycle a collision flag is raised, unless the register is register 0. Register 0 is hard-wired to zero.

Top module: `dual_wr_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero on the rising clock edge.
- R2: Each read port returns the selected register's contents combinationally; a read in the same cycle as a write returns the value held before that edge.
- R3: An enabled primary port stores its data in the register named by its address on the rising edge; no other register changes because of it.
- R4: An enabled secondary port stores its data in the register named by its own address on the rising edge; no other register changes because of it.
- R5: With both ports enabled and different addresses, both registers are updated on the same edge, so crossing the values of two registers swaps them in one cycle.
- R6: With both ports enabled and equal addresses, the register takes the primary port's data and the secondary port's data is discarded.
- R7: Register 0 always reads as zero, and a write to it from either port has no effect.
- R8: The collision output is 1 exactly when both enables are high and the two write addresses are equal and nonzero, and 0 otherwise. It is combinational.
- R9: A port whose enable is low writes nothing, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | AW | Read port A address |
| rd_data_a | output | DW | Read port A data |
| rd_addr_b | input | AW | Read port B address |
| rd_data_b | output | DW | Read port B data |
| wp_en | input | 1 | Primary write enable |
| wp_addr | input | AW | Primary write address |
| wp_data | input | DW | Primary write data |
| ws_en | input | 1 | Secondary write enable |
| ws_addr | input | AW | Secondary write address |
| ws_data | input | DW | Secondary write data |
| wr_clash | output | 1 | Both ports enabled on the same nonzero register |

## Verification
The main function is tried with several input patterns:
- Single writes through each port, which show whether the data is steered to the right register.
- Crossed swaps of two distinct registers, which show whether both ports commit on the same edge and whether a read returns the old value.
- Same-address pairs, which show whether the primary port wins and whether the collision flag is raised.
- Writes to register 0 through either port, and pairs of ports addressing register 0 together, which show whether the zero register stays zero and whether the flag is masked for it.

A stretch of random traffic then mixes all of these cases. After every edge, all registers are compared against a behavioural model through the read ports.

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wp_en,
  input  logic [AW-1:0] wp_addr,
  input  logic [DW-1:0] wp_data,
  input  logic          ws_en,
  input  logic [AW-1:0] ws_addr,
  input  logic [DW-1:0] ws_data,
  output logic          wr_clash
);

  logic [DW-1:0] regs [NREG];

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];
  assign wr_clash  = wp_en && ws_en && (wp_addr == ws_addr) && (wp_addr != '0);

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic hit_p, hit_s;
    assign hit_p = wp_en && (wp_addr == AW'(i));
    assign hit_s = ws_en && (ws_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (rst)        regs[i] <= '0;
      else if (hit_p) regs[i] <= wp_data;
      else if (hit_s) regs[i] <= ws_data;
    end
  end

endmodule

module dual_wr_regfile_chk #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_addr_a,
  input logic [DW-1:0] rd_data_a,
  input logic [AW-1:0] rd_addr_b,
  input logic [DW-1:0] rd_data_b,
  input logic          wp_en,
  input logic [AW-1:0] wp_addr,
  input logic [DW-1:0] wp_data,
  input logic          ws_en,
  input logic [AW-1:0] ws_addr,
  input logic [DW-1:0] ws_data,
  input logic          wr_clash
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  AST_ZERO_READ_A: assert property (@(posedge clk) (rd_addr_a == '0) |-> (rd_data_a == '0)); // R7
  AST_ZERO_READ_B: assert property (@(posedge clk) (rd_addr_b == '0) |-> (rd_data_b == '0)); // R7
  AST_CLASH_NEEDS_BOTH: assert property (@(posedge clk) wr_clash |-> (wp_en && ws_en)); // R8
  AST_CLASH_NOT_ZERO: assert property (@(posedge clk) wr_clash |-> (ws_addr != '0)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0)); // R1
  AST_PRIMARY_WINS: assert property (@(posedge clk) disable iff (rst)
    (live && wr_clash && rd_addr_a == wp_addr) |=> (rd_data_a == $past(wp_data)) || $changed(rd_addr_a)); // R6
endmodule

bind dual_wr_regfile dual_wr_regfile_chk #(.NREG(NREG), .DW(DW)) u_chk (.*);

// File: tb/test_dual_wr_regfile.sv
module test_dual_wr_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 0, rst = 1;
  logic [AW-1:0] rd_addr_a = 0, rd_addr_b = 0, wp_addr = 0, ws_addr = 0;
  logic [DW-1:0] rd_data_a, rd_data_b, wp_data = 0, ws_data = 0;
  logic wp_en = 0, ws_en = 0, wr_clash;

  int tests = 0, fails = 0;
  logic [DW-1:0] model [NREG];

  dual_wr_regfile #(.NREG(NREG), .DW(DW)) i_dual_wr_regfile (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*100000);
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NREG; i++) begin
      rd_addr_a = AW'(i); rd_addr_b = AW'(NREG-1-i);
      #1;
      chk(req, rd_data_a, model[i]);
      chk(req, rd_data_b, model[NREG-1-i]);
    end
  endtask

  task automatic cyc(logic pe, logic [AW-1:0] pa, logic [DW-1:0] pd,
                     logic se, logic [AW-1:0] sa, logic [DW-1:0] sd, string req);
    logic exp_clash;
    wp_en = pe; wp_addr = pa; wp_data = pd;
    ws_en = se; ws_addr = sa; ws_data = sd;
    rd_addr_a = pa; rd_addr_b = sa;
    #1;
    exp_clash = pe && se && pa == sa && pa != 0;
    chk({"R8 ", req}, {31'd0, wr_clash}, {31'd0, exp_clash});
    chk({"R2 ", req}, rd_data_a, model[pa]);
    chk({"R2 ", req}, rd_data_b, model[sa]);
    @(posedge clk);
    if (se && sa != 0) model[sa] = sd;
    if (pe && pa != 0) model[pa] = pd;
    #2;
    wp_en = 0; ws_en = 0;
    check_all(req);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 0;
    @(posedge clk); @(posedge clk); #2;
    rst = 0;
    check_all("R1 reset");
    for (int i = 1; i < 8; i++) cyc(1, AW'(i), 32'hA000_0000 + i, 0, 0, 0, "R3 primary");
    for (int i = 8; i < 16; i++) cyc(0, 0, 0, 1, AW'(i), 32'hB000_0000 + i, "R4 secondary");
    cyc(0, 5, 32'hDEAD, 0, 6, 32'hBEEF, "R9 disabled");
    cyc(1, 3, model[10], 1, 10, model[3], "R5 swap");
    cyc(1, 20, 32'h1111, 1, 20, 32'h2222, "R6 clash");
    cyc(1, 0, 32'hFFFF, 0, 0, 0, "R7 zero primary");
    cyc(0, 0, 0, 1, 0, 32'hFFFF, "R7 zero secondary");
    cyc(1, 0, 32'h1, 1, 0, 32'h2, "R7 R8 zero both");
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 7)), b = AW'($urandom_range(0, 7));
      cyc(1'($urandom), a, $urandom, 1'($urandom), b, $urandom, "R3 R4 R5 R6 random");
    end
    rst = 1; @(posedge clk); #2; rst = 0;
    for (int i = 0; i < NREG; i++) model[i] = 0;
    check_all("R1 reset again");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule